// File: doc/BRIEF.md
# Lane-Parallel Windowed Sum Updater

This block keeps the running sum and the running sum of squares of a sliding box window for many pixel lanes at once. Each accepted transfer carries two packed words of signed pixels. One word holds the pixel that enters the window and the other holds the pixel that leaves it. For every lane the block forms the change in the sum (entering minus leaving) and the change in the sum of squares (entering squared minus leaving squared). It then adds both changes into packed per-lane accumulators.

The work is split over two register stages. The first stage turns the pixel pair into sign-extended deltas. The second stage adds those deltas into the accumulators. A valid/ready pair on the input and on the output lets a downstream consumer hold the pipeline, and one transfer per clock is accepted while nothing is held. A synchronous clear empties the pipeline and zeroes every accumulator lane, so a new window can start.

Top module: `lane_window_acc`

## Requirements
- R1: Pixel lane i occupies bits [PIX_W*i+PIX_W-1 : PIX_W*i] of both pixel inputs. Sum lane i occupies bits [SUM_W*i+SUM_W-1 : SUM_W*i] of `sum_q`, and square lane i occupies bits [SUM2_W*i+SUM2_W-1 : SUM2_W*i] of `sum2_q`. Defaults are 32 lanes, PIX_W=16, SUM_W=24 and SUM2_W=40.
- R2: For each accepted transfer, every sum lane grows by (add − sub). Both pixels are read as two's-complement values, and the delta is sign-extended to SUM_W.
- R3: For each accepted transfer, every square lane grows by (add² − sub²), computed signed and sign-extended to SUM2_W.
- R4: Lanes are independent. Each lane wraps modulo 2^SUM_W (or 2^SUM2_W), and no carry passes into a neighbouring lane.
- R5: A transfer is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its effect appears on the accumulators on the next rising edge, together with `out_valid` high. Back-to-back transfers update the accumulators on consecutive edges. The accumulators change only on an edge that raises or renews `out_valid`, or on a clear.
- R6: With `clr` high at a rising edge, every lane of both accumulators becomes zero and `out_valid` goes low. Any transfer still held in the first stage is discarded. Clear wins over an update due on the same edge.
- R7: `in_ready` is low while `clr` is high. When `clr` is low, `in_ready` is low only if the first stage is full and the output is held (`out_valid` high and `out_ready` low).
- R8: While `out_valid` is high and `out_ready` is low (and `clr` is low), the accumulators hold their value and `out_valid` stays high.
- R9: While `rst` is high and after it falls, the accumulators read zero, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of accumulators and pipeline |
| in_valid | input | 1 | Pixel pair offered |
| in_ready | output | 1 | Pixel pair can be taken this cycle |
| add_px | input | LANES*PIX_W | Packed pixels entering the window |
| sub_px | input | LANES*PIX_W | Packed pixels leaving the window |
| out_valid | output | 1 | Accumulators hold a fresh, unconsumed update |
| out_ready | input | 1 | Consumer takes the current update |
| sum_q | output | LANES*SUM_W | Packed per-lane sums |
| sum2_q | output | LANES*SUM2_W | Packed per-lane sums of squares |

## Verification
A transfer accepted on one rising edge is due on the accumulators one edge later, with `out_valid` raised at that same edge. A clear is due on the edge that samples it. `in_ready` is combinational and is due in the same cycle as the `clr` and `out_ready` that drive it. The bench applies each cycle's inputs after the falling edge and compares every output one time unit later. Its behavioural model takes exactly one step per rising edge, so each comparison sees the state produced by all the edges so far and nothing more.

// File: rtl/lane_sum_pkg.sv
package lane_sum_pkg;

    localparam int LANES_DEF  = 32;
    localparam int PIX_W_DEF  = 16;
    localparam int SUM_W_DEF  = 24;
    localparam int SUM2_W_DEF = 40;

    // Action applied to the accumulator bank on an edge
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_ZERO = 2'd2
    } acc_op_e;

    // Low bit of lane 'lane' in a packed word of 'w'-bit lanes
    function automatic int lane_lo(input int lane, input int w);
        return lane * w;
    endfunction

endpackage

// File: rtl/lane_delta_stage.sv
module lane_delta_stage
    import lane_sum_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int PIX_W  = PIX_W_DEF,
    parameter int SUM_W  = SUM_W_DEF,
    parameter int SUM2_W = SUM2_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    load,
    input  logic                    take,
    input  logic [LANES*PIX_W-1:0]  add_px,
    input  logic [LANES*PIX_W-1:0]  sub_px,
    output logic                    full,
    output logic [LANES*SUM_W-1:0]  d_sum,
    output logic [LANES*SUM2_W-1:0] d_sq
);
    localparam int D1_W = PIX_W + 1;
    localparam int SQ_W = 2 * PIX_W;
    localparam int D2_W = SQ_W + 1;

    always_ff @(posedge clk) begin
        if (rst || flush)
            full <= 1'b0;
        else if (load)
            full <= 1'b1;
        else if (take)
            full <= 1'b0;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [PIX_W-1:0] px_a, px_b;
        logic signed [D1_W-1:0]  lin_d;
        logic signed [SQ_W-1:0]  sq_a, sq_b;
        logic signed [D2_W-1:0]  sq_d;
        logic [SUM_W-1:0]        lin_r;
        logic [SUM2_W-1:0]       sq_r;

        always_comb begin
            px_a  = add_px[lane_lo(g, PIX_W) +: PIX_W];
            px_b  = sub_px[lane_lo(g, PIX_W) +: PIX_W];
            lin_d = D1_W'(px_a) - D1_W'(px_b);
            sq_a  = SQ_W'(px_a) * SQ_W'(px_a);
            sq_b  = SQ_W'(px_b) * SQ_W'(px_b);
            sq_d  = D2_W'(sq_a) - D2_W'(sq_b);
        end

        always_ff @(posedge clk) begin
            if (load) begin
                lin_r <= SUM_W'(lin_d);
                sq_r  <= SUM2_W'(sq_d);
            end
        end

        assign d_sum[lane_lo(g, SUM_W) +: SUM_W]   = lin_r;
        assign d_sq[lane_lo(g, SUM2_W) +: SUM2_W]  = sq_r;
    end

endmodule

// File: rtl/lane_accum_bank.sv
module lane_accum_bank
    import lane_sum_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int SUM_W  = SUM_W_DEF,
    parameter int SUM2_W = SUM2_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  acc_op_e                 op,
    input  logic [LANES*SUM_W-1:0]  d_sum,
    input  logic [LANES*SUM2_W-1:0] d_sq,
    output logic [LANES*SUM_W-1:0]  acc_sum,
    output logic [LANES*SUM2_W-1:0] acc_sq
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SUM_W-1:0]  a_lin;
        logic [SUM2_W-1:0] a_sq;

        always_ff @(posedge clk) begin
            if (rst) begin
                a_lin <= '0;
                a_sq  <= '0;
            end else begin
                case (op)
                    ACC_ZERO: begin
                        a_lin <= '0;
                        a_sq  <= '0;
                    end
                    ACC_ADD: begin
                        a_lin <= a_lin + d_sum[lane_lo(g, SUM_W) +: SUM_W];
                        a_sq  <= a_sq + d_sq[lane_lo(g, SUM2_W) +: SUM2_W];
                    end
                    default: ;
                endcase
            end
        end

        assign acc_sum[lane_lo(g, SUM_W) +: SUM_W]  = a_lin;
        assign acc_sq[lane_lo(g, SUM2_W) +: SUM2_W] = a_sq;
    end

endmodule

// File: rtl/lane_window_acc.sv
module lane_window_acc
    import lane_sum_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int PIX_W  = PIX_W_DEF,
    parameter int SUM_W  = SUM_W_DEF,
    parameter int SUM2_W = SUM2_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*PIX_W-1:0]  add_px,
    input  logic [LANES*PIX_W-1:0]  sub_px,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*SUM_W-1:0]  sum_q,
    output logic [LANES*SUM2_W-1:0] sum2_q
);
    logic                    s1_full;
    logic                    s2_go;
    logic                    s1_load;
    acc_op_e                 bank_op;
    logic [LANES*SUM_W-1:0]  d_sum;
    logic [LANES*SUM2_W-1:0] d_sq;

    assign s2_go    = s1_full && (!out_valid || out_ready);
    assign in_ready = !clr && (!s1_full || s2_go);
    assign s1_load  = in_valid && in_ready;

    always_comb begin
        if (clr)
            bank_op = ACC_ZERO;
        else if (s2_go)
            bank_op = ACC_ADD;
        else
            bank_op = ACC_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            out_valid <= 1'b0;
        else if (s2_go)
            out_valid <= 1'b1;
        else if (out_ready)
            out_valid <= 1'b0;
    end

    lane_delta_stage #(
        .LANES(LANES), .PIX_W(PIX_W), .SUM_W(SUM_W), .SUM2_W(SUM2_W)
    ) u_delta (
        .clk    (clk),
        .rst    (rst),
        .flush  (clr),
        .load   (s1_load),
        .take   (s2_go),
        .add_px (add_px),
        .sub_px (sub_px),
        .full   (s1_full),
        .d_sum  (d_sum),
        .d_sq   (d_sq)
    );

    lane_accum_bank #(
        .LANES(LANES), .SUM_W(SUM_W), .SUM2_W(SUM2_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .op      (bank_op),
        .d_sum   (d_sum),
        .d_sq    (d_sq),
        .acc_sum (sum_q),
        .acc_sq  (sum2_q)
    );

endmodule

// File: rtl/lane_window_acc_chk.sv
module lane_window_acc_chk #(
    parameter int LANES  = 32,
    parameter int SUM_W  = 24,
    parameter int SUM2_W = 40
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    clr,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LANES*SUM_W-1:0]  sum_q,
    input logic [LANES*SUM2_W-1:0] sum2_q
);
    p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && sum_q == '0 && sum2_q == '0));

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!out_valid && sum_q == '0 && sum2_q == '0));

    p_clear_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        clr |-> !in_ready);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !clr) |=>
            (out_valid && $stable(sum_q) && $stable(sum2_q)));

    p_change_flag_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sum_q) |-> (out_valid || $past(clr)));

    p_sq_change_flag_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sum2_q) |-> (out_valid || $past(clr)));

endmodule

bind lane_window_acc lane_window_acc_chk #(
    .LANES(LANES), .SUM_W(SUM_W), .SUM2_W(SUM2_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .sum_q     (sum_q),
    .sum2_q    (sum2_q)
);

// File: tb/sim_lane_window_acc.sv
module sim_lane_window_acc;
    localparam int LANES  = 32;
    localparam int PIX_W  = 16;
    localparam int SUM_W  = 24;
    localparam int SUM2_W = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic in_valid = 1'b0;
    logic out_ready = 1'b1;
    logic in_ready, out_valid;
    logic [LANES*PIX_W-1:0]  add_px = '0;
    logic [LANES*PIX_W-1:0]  sub_px = '0;
    logic [LANES*SUM_W-1:0]  sum_q;
    logic [LANES*SUM2_W-1:0] sum2_q;

    always #5 clk = ~clk;

    lane_window_acc #(
        .LANES(LANES), .PIX_W(PIX_W), .SUM_W(SUM_W), .SUM2_W(SUM2_W)
    ) u0 (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .in_ready(in_ready), .add_px(add_px), .sub_px(sub_px),
        .out_valid(out_valid), .out_ready(out_ready),
        .sum_q(sum_q), .sum2_q(sum2_q)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string cur_tag = "R9";

    // reference state
    longint m_sum[LANES];
    longint m_sq[LANES];
    longint q_lin[LANES];
    longint q_sq[LANES];
    int     cur_a[LANES];
    int     cur_b[LANES];
    bit     m_full = 0;
    bit     m_ov = 0;

    localparam longint MASK1 = (longint'(1) << SUM_W) - 1;
    localparam longint MASK2 = (longint'(1) << SUM2_W) - 1;

    function automatic logic [31:0] hsh(input int a, input int b);
        logic [31:0] x;
        x = 32'(a) * 32'd1103515245 + 32'(b) * 32'd12345 + 32'd1013904223;
        x = x ^ (x >> 15);
        x = x * 32'd2654435761;
        return x ^ (x >> 13);
    endfunction

    function automatic int pix(input int pat, input int c, input int lane, input bit leaving);
        logic [31:0] h;
        case (pat)
            0: return leaving ? 0 : lane * 3 - 40;
            1: return leaving ? lane : 2;
            2: begin
                if (lane % 2 == 0) return leaving ? 0 : -32768;
                return leaving ? -32768 : 32767;
            end
            default: begin
                h = hsh(c, lane * 2 + int'(leaving));
                return int'($signed(h[23:8]));
            end
        endcase
    endfunction

    task automatic check(input string tag, input bit ok, input string what,
                         input longint got, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    task automatic compare();
        bit m_rdy;
        longint g1, g2;
        int e1, e2;
        m_rdy = !clr && (!m_full || (!m_ov || out_ready));
        check("R7", in_ready == m_rdy, "in_ready", longint'(in_ready), longint'(m_rdy));
        check("R5", out_valid == m_ov, "out_valid", longint'(out_valid), longint'(m_ov));
        e1 = -1; e2 = -1;
        for (int l = 0; l < LANES; l++) begin
            g1 = longint'(sum_q[l*SUM_W +: SUM_W]);
            g2 = longint'(sum2_q[l*SUM2_W +: SUM2_W]);
            if (e1 < 0 && g1 != (m_sum[l] & MASK1)) e1 = l;
            if (e2 < 0 && g2 != (m_sq[l] & MASK2)) e2 = l;
        end
        if (e1 >= 0)
            check(cur_tag, 1'b0, $sformatf("sum lane %0d", e1),
                  longint'(sum_q[e1*SUM_W +: SUM_W]), m_sum[e1] & MASK1);
        else
            check(cur_tag, 1'b1, "sum", 0, 0);
        if (e2 >= 0)
            check(cur_tag, 1'b0, $sformatf("sum2 lane %0d", e2),
                  longint'(sum2_q[e2*SUM2_W +: SUM2_W]), m_sq[e2] & MASK2);
        else
            check(cur_tag, 1'b1, "sum2", 0, 0);
    endtask

    task automatic advance();
        bit go2, rdy;
        if (rst || clr) begin
            m_full = 0;
            m_ov = 0;
            for (int l = 0; l < LANES; l++) begin
                m_sum[l] = 0;
                m_sq[l] = 0;
            end
        end else begin
            go2 = m_full && (!m_ov || out_ready);
            rdy = !m_full || go2;
            if (go2)
                for (int l = 0; l < LANES; l++) begin
                    m_sum[l] = (m_sum[l] + q_lin[l]) & MASK1;
                    m_sq[l]  = (m_sq[l] + q_sq[l]) & MASK2;
                end
            if (go2) m_ov = 1;
            else if (out_ready) m_ov = 0;
            if (in_valid && rdy) begin
                for (int l = 0; l < LANES; l++) begin
                    q_lin[l] = longint'(cur_a[l]) - longint'(cur_b[l]);
                    q_sq[l]  = longint'(cur_a[l]) * cur_a[l] - longint'(cur_b[l]) * cur_b[l];
                end
                m_full = 1;
            end else if (go2) begin
                m_full = 0;
            end
        end
    endtask

    task automatic step(input bit r, input bit c, input bit v, input bit o, input int pat);
        @(negedge clk);
        rst = r; clr = c; in_valid = v; out_ready = o;
        for (int l = 0; l < LANES; l++) begin
            cur_a[l] = pix(pat, cyc, l, 1'b0);
            cur_b[l] = pix(pat, cyc, l, 1'b1);
            add_px[l*PIX_W +: PIX_W] = PIX_W'(cur_a[l]);
            sub_px[l*PIX_W +: PIX_W] = PIX_W'(cur_b[l]);
        end
        #1;
        compare();
        advance();
        cyc++;
    endtask

    initial begin
        for (int l = 0; l < LANES; l++) begin
            m_sum[l] = 0; m_sq[l] = 0; q_lin[l] = 0; q_sq[l] = 0;
        end
        // R9: reset state and idle after reset
        cur_tag = "R9";
        repeat (3) step(1, 0, 0, 1, 0);
        repeat (2) step(0, 0, 0, 1, 0);
        // R1: lane placement with a lane-dependent ramp
        cur_tag = "R1";
        repeat (12) step(0, 0, 1, 1, 0);
        // R3: square deltas 4 - i*i
        cur_tag = "R3";
        repeat (12) step(0, 0, 1, 1, 1);
        // R8: irregular valid and backpressure
        cur_tag = "R8";
        for (int k = 0; k < 60; k++) begin
            logic [31:0] h;
            h = hsh(k, 901);
            step(0, 0, h[3:0] != 4'd0, h[7:6] != 2'd0, 3);
        end
        repeat (4) step(0, 0, 1, 0, 3);
        // R6: clear mid-stream, and clear while stalled
        cur_tag = "R6";
        repeat (3) step(0, 0, 1, 1, 3);
        step(0, 1, 1, 1, 3);
        repeat (3) step(0, 0, 1, 1, 3);
        repeat (3) step(0, 0, 1, 0, 3);
        step(0, 1, 1, 0, 3);
        repeat (4) step(0, 0, 1, 1, 3);
        // R4: long run of extremes so every lane wraps
        cur_tag = "R4";
        step(0, 1, 0, 1, 2);
        repeat (1100) step(0, 0, 1, 1, 2);
        // R2: random pixels, handshakes and occasional clears
        cur_tag = "R2";
        for (int k = 0; k < 400; k++) begin
            logic [31:0] h;
            h = hsh(k, 4242);
            step(0, (h % 41) == 0, h[9:8] != 2'd0, h[12:11] != 2'd0, 3);
        end
        repeat (4) step(0, 0, 0, 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule